// File: doc/BRIEF.md
# Target Claim Latency Timer

This block sits on the target side of a shared parallel bus. When a transaction starts and the address decoder reports a hit, it drives the active-low device-select claim after a fixed number of clocks. The number is picked by a 2-bit speed setting with three values: fast (one clock), medium (two clocks) and slow (three clocks). The claim then stays asserted until the data path reports the end of the transaction. A claim never comes later than the third clock after the start.

The target-ready request and the read data drive-enable request from the data path both pass through a registered gate. Neither can reach the bus until the claim has been active for at least one cycle. The effective speed category is also presented as a read-only 2-bit status field. Address decoding, data movement and master-side abort handling are left to neighbouring logic.

Top module: `tgt_claim_timer`

## Requirements
- R1: While reset is active and after it is released with no transaction, `claim_n_o` is 1, `trdy_n_o` is 1, `data_oe_o` is 0 and `stat_speed_o` is 2'b00.
- R2: With `speed_cfg_i` = 2'b00 (fast), a start sampled with a hit on clock edge N drives `claim_n_o` low right after edge N.
- R3: With `speed_cfg_i` = 2'b01 (medium), `claim_n_o` goes low right after edge N+1 and is high before that.
- R4: With `speed_cfg_i` = 2'b10 (slow), `claim_n_o` goes low right after edge N+2. The reserved code 2'b11 behaves exactly as slow.
- R5: A start sampled while `addr_hit_i` is 0 leaves the block idle. `claim_n_o`, `trdy_n_o` and `data_oe_o` stay deasserted even when the data path requests them.
- R6: Once asserted, the claim stays low until `txn_end_i` is sampled high. After that edge, `claim_n_o` is 1, `trdy_n_o` is 1 and `data_oe_o` is 0.
- R7: `trdy_n_o` goes low, and `data_oe_o` goes high, only on an edge where the claim was already active and the matching request is high. Neither is ever active while `claim_n_o` is 1.
- R8: `stat_speed_o` shows the speed setting sampled on the previous edge. The code 2'b11 is reported as 2'b10, so the field never reads 2'b11.
- R9: The speed is captured at the accepted start. Changing `speed_cfg_i` while the claim is pending does not move the claim edge.
- R10: A start pulse that arrives while a transaction is pending or claimed is ignored and does not restart the latency count.
- R11: `txn_end_i` sampled while the claim is still pending cancels it, and the claim is not asserted for that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_start_i | input | 1 | One-cycle strobe marking the start of a bus transaction |
| addr_hit_i | input | 1 | Address decoder hit, sampled with the start strobe |
| txn_end_i | input | 1 | One-cycle strobe marking the end of the transaction |
| trdy_req_i | input | 1 | Target-ready request from the data path |
| data_oe_req_i | input | 1 | Read data drive-enable request from the data path |
| speed_cfg_i | input | 2 | Claim speed: 00 fast, 01 medium, 10 slow, 11 treated as slow |
| claim_n_o | output | 1 | Registered device-select claim, active low |
| trdy_n_o | output | 1 | Registered, gated target-ready, active low |
| data_oe_o | output | 1 | Registered, gated read data drive enable, active high |
| stat_speed_o | output | 2 | Read-only status field holding the effective speed code |

## Verification
The bench counts the clock at which the claim appears for each speed code, including the reserved one. An off-by-one sequencer would claim a cycle early or late, and a decoder that passes 2'b11 through unchanged would report a bad status or pick the wrong delay. Target-ready and drive-enable are requested before the start, so a gate that looks at the request alone would drive the bus while the claim is still high. Second starts and early ends are sent during the pending window: a design that restarts on a fresh start claims too early, and one that ignores an early end claims for a transaction that has already finished.

// File: rtl/tgt_claim_pkg.sv
package tgt_claim_pkg;

   typedef enum logic [1:0] {
      SPD_FAST = 2'b00,
      SPD_MED  = 2'b01,
      SPD_SLOW = 2'b10,
      SPD_RSVD = 2'b11
   } speed_e;

   typedef enum logic [1:0] {
      CS_IDLE  = 2'b00,
      CS_WAIT  = 2'b01,
      CS_CLAIM = 2'b10
   } claim_st_e;

   // reserved code folds onto the slowest category
   function automatic speed_e norm_speed(input logic [1:0] code);
      speed_e s;
      if (code == 2'b11) s = SPD_SLOW;
      else               s = speed_e'(code);
      return s;
   endfunction

endpackage

// File: rtl/tgt_speed_decode.sv
module tgt_speed_decode
   import tgt_claim_pkg::*;
#(
   parameter int FAST_DLY = 1,
   parameter int MED_DLY  = 2,
   parameter int SLOW_DLY = 3,
   parameter int CNT_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       speed_cfg_i,
   output logic [CNT_W-1:0] dly_o,
   output logic [1:0]       stat_o
);

   localparam logic [CNT_W-1:0] FastD = CNT_W'(FAST_DLY);
   localparam logic [CNT_W-1:0] MedD  = CNT_W'(MED_DLY);
   localparam logic [CNT_W-1:0] SlowD = CNT_W'(SLOW_DLY);

   speed_e eff_spd;
   logic [1:0] stat_q;

   always_comb begin
      eff_spd = norm_speed(speed_cfg_i);
      unique case (eff_spd)
         SPD_FAST: dly_o = FastD;
         SPD_MED:  dly_o = MedD;
         default:  dly_o = SlowD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= 2'b00;
      else        stat_q <= eff_spd;
   end

   assign stat_o = stat_q;

   // R8
   stat_no_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o != 2'b11);

   // R8
   stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (speed_cfg_i != 2'b11) |=> (stat_o == $past(speed_cfg_i)));

endmodule

// File: rtl/tgt_claim_seq.sv
module tgt_claim_seq
   import tgt_claim_pkg::*;
#(
   parameter int SLOW_DLY = 3,
   parameter int CNT_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             hit_i,
   input  logic             end_i,
   input  logic [CNT_W-1:0] dly_i,
   output logic             claim_act_o,
   output logic             claim_n_o
);

   localparam logic [CNT_W-1:0] One = CNT_W'(1);

   claim_st_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] wait_cyc_q;
   logic             claim_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= CS_IDLE;
         cnt_q      <= '0;
         wait_cyc_q <= '0;
         claim_n_q  <= 1'b1;
      end else begin
         unique case (st_q)
            CS_IDLE: begin
               wait_cyc_q <= '0;
               if (start_i && hit_i) begin
                  if (dly_i <= One) begin
                     st_q      <= CS_CLAIM;
                     claim_n_q <= 1'b0;
                  end else begin
                     st_q  <= CS_WAIT;
                     cnt_q <= dly_i - One;
                  end
               end
            end
            CS_WAIT: begin
               wait_cyc_q <= wait_cyc_q + One;
               if (end_i) begin
                  st_q <= CS_IDLE;
               end else if (cnt_q == One) begin
                  st_q      <= CS_CLAIM;
                  claim_n_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - One;
               end
            end
            CS_CLAIM: begin
               if (end_i) begin
                  st_q      <= CS_IDLE;
                  claim_n_q <= 1'b1;
               end
            end
            default: begin
               st_q      <= CS_IDLE;
               claim_n_q <= 1'b1;
            end
         endcase
      end
   end

   assign claim_act_o = (st_q == CS_CLAIM);
   assign claim_n_o   = claim_n_q;

   // R6
   claim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!claim_n_o && !end_i) |=> !claim_n_o);

   // R6
   claim_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!claim_n_o && end_i) |=> claim_n_o);

   // R5
   nohit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CS_IDLE && start_i && !hit_i) |=> claim_n_o);

   // R11
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CS_WAIT && end_i) |=> claim_n_o);

   // R4
   claim_deadline_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CS_WAIT) |-> (wait_cyc_q < CNT_W'(SLOW_DLY)));

endmodule

// File: rtl/tgt_ready_gate.sv
module tgt_ready_gate #(
   parameter int                      NUM_LANES    = 2,
   parameter logic [NUM_LANES-1:0]    LANE_ACT_LOW = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 claim_act_i,
   input  logic                 end_i,
   input  logic [NUM_LANES-1:0] req_i,
   output logic [NUM_LANES-1:0] lane_o
);

   logic open_c;
   assign open_c = claim_act_i && !end_i;

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      logic lane_q;
      logic lane_on;
      if (LANE_ACT_LOW[i]) begin : g_low
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= 1'b1;
            else        lane_q <= !(req_i[i] && open_c);
         end
         assign lane_on = !lane_q;
      end else begin : g_high
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= 1'b0;
            else        lane_q <= req_i[i] && open_c;
         end
         assign lane_on = lane_q;
      end
      assign lane_o[i] = lane_q;

      // R7
      lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(lane_on) |-> ($past(claim_act_i) && $past(req_i[i])));
   end

endmodule

// File: rtl/tgt_claim_timer.sv
module tgt_claim_timer #(
   parameter int FAST_DLY = 1,
   parameter int MED_DLY  = 2,
   parameter int SLOW_DLY = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       txn_start_i,
   input  logic       addr_hit_i,
   input  logic       txn_end_i,
   input  logic       trdy_req_i,
   input  logic       data_oe_req_i,
   input  logic [1:0] speed_cfg_i,
   output logic       claim_n_o,
   output logic       trdy_n_o,
   output logic       data_oe_o,
   output logic [1:0] stat_speed_o
);

   localparam int CntW  = $clog2(SLOW_DLY + 1);
   localparam int Lanes = 2;

   initial begin
      fast_min_chk: assert (FAST_DLY >= 1)
         else $error("fast delay must be at least one clock");
      order_chk: assert (FAST_DLY <= MED_DLY && MED_DLY <= SLOW_DLY)
         else $error("delays must not decrease with speed");
      slow_max_chk: assert (SLOW_DLY <= 3)
         else $error("slow delay exceeds the three-clock claim limit");
   end

   logic [CntW-1:0]  dly_w;
   logic             claim_act_w;
   logic [Lanes-1:0] lane_w;

   tgt_speed_decode #(
      .FAST_DLY (FAST_DLY),
      .MED_DLY  (MED_DLY),
      .SLOW_DLY (SLOW_DLY),
      .CNT_W    (CntW)
   ) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .speed_cfg_i (speed_cfg_i),
      .dly_o       (dly_w),
      .stat_o      (stat_speed_o)
   );

   tgt_claim_seq #(
      .SLOW_DLY (SLOW_DLY),
      .CNT_W    (CntW)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (txn_start_i),
      .hit_i       (addr_hit_i),
      .end_i       (txn_end_i),
      .dly_i       (dly_w),
      .claim_act_o (claim_act_w),
      .claim_n_o   (claim_n_o)
   );

   tgt_ready_gate #(
      .NUM_LANES    (Lanes),
      .LANE_ACT_LOW (2'b01)
   ) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .claim_act_i (claim_act_w),
      .end_i       (txn_end_i),
      .req_i       ({data_oe_req_i, trdy_req_i}),
      .lane_o      (lane_w)
   );

   assign trdy_n_o  = lane_w[0];
   assign data_oe_o = lane_w[1];

   // R7
   trdy_after_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trdy_n_o |-> !claim_n_o);

   // R7
   oe_after_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe_o |-> !claim_n_o);

endmodule

// File: tb/tgt_claim_timer_tb.sv
module tgt_claim_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       txn_start_i = 1'b0;
   logic       addr_hit_i = 1'b0;
   logic       txn_end_i = 1'b0;
   logic       trdy_req_i = 1'b0;
   logic       data_oe_req_i = 1'b0;
   logic [1:0] speed_cfg_i = 2'b00;
   logic       claim_n_o;
   logic       trdy_n_o;
   logic       data_oe_o;
   logic [1:0] stat_speed_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tgt_claim_timer u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .txn_start_i   (txn_start_i),
      .addr_hit_i    (addr_hit_i),
      .txn_end_i     (txn_end_i),
      .trdy_req_i    (trdy_req_i),
      .data_oe_req_i (data_oe_req_i),
      .speed_cfg_i   (speed_cfg_i),
      .claim_n_o     (claim_n_o),
      .trdy_n_o      (trdy_n_o),
      .data_oe_o     (data_oe_o),
      .stat_speed_o  (stat_speed_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   // start pulse; returns at the negedge after the sampling edge N
   task automatic kick(input logic hit);
      txn_start_i = 1'b1;
      addr_hit_i  = hit;
      cyc();
      txn_start_i = 1'b0;
      addr_hit_i  = 1'b0;
   endtask

   task automatic finish_txn();
      txn_end_i = 1'b1;
      cyc();
      txn_end_i = 1'b0;
      cyc();
   endtask

   task automatic t_reset();
      chk("R1 claim_n in reset", claim_n_o, 1);
      chk("R1 trdy_n in reset", trdy_n_o, 1);
      chk("R1 data_oe in reset", data_oe_o, 0);
      chk("R1 status in reset", stat_speed_o, 0);
      rst_n = 1'b1;
      cyc();
      cyc();
      chk("R1 claim_n idle", claim_n_o, 1);
      chk("R1 trdy_n idle", trdy_n_o, 1);
   endtask

   task automatic t_latency(input logic [1:0] code, input int d, input string tag);
      speed_cfg_i = code;
      cyc();
      kick(1'b1);
      for (int k = 1; k <= 4; k++) begin
         chk(tag, claim_n_o, (k >= d) ? 0 : 1);
         if (k < 4) cyc();
      end
      finish_txn();
      chk("R6 claim released", claim_n_o, 1);
   endtask

   task automatic t_nohit();
      speed_cfg_i   = 2'b00;
      trdy_req_i    = 1'b1;
      data_oe_req_i = 1'b1;
      kick(1'b0);
      for (int k = 1; k <= 3; k++) begin
         chk("R5 no claim without hit", claim_n_o, 1);
         chk("R5 no trdy without hit", trdy_n_o, 1);
         chk("R5 no oe without hit", data_oe_o, 0);
         cyc();
      end
      trdy_req_i    = 1'b0;
      data_oe_req_i = 1'b0;
   endtask

   task automatic t_gate_hold();
      speed_cfg_i   = 2'b00;
      trdy_req_i    = 1'b1;
      data_oe_req_i = 1'b1;
      kick(1'b1);
      chk("R2 fast claim", claim_n_o, 0);
      chk("R7 trdy held off first claim cycle", trdy_n_o, 1);
      chk("R7 oe held off first claim cycle", data_oe_o, 0);
      cyc();
      chk("R7 trdy after claim", trdy_n_o, 0);
      chk("R7 oe after claim", data_oe_o, 1);
      for (int k = 0; k < 5; k++) cyc();
      chk("R6 claim held", claim_n_o, 0);
      txn_end_i = 1'b1;
      cyc();
      txn_end_i = 1'b0;
      chk("R6 claim off after end", claim_n_o, 1);
      chk("R6 trdy off after end", trdy_n_o, 1);
      chk("R6 oe off after end", data_oe_o, 0);
      trdy_req_i    = 1'b0;
      data_oe_req_i = 1'b0;
      cyc();
   endtask

   task automatic t_status();
      speed_cfg_i = 2'b11;
      cyc();
      chk("R8 reserved reported as slow", stat_speed_o, 2);
      speed_cfg_i = 2'b01;
      chk("R8 status lags one edge", stat_speed_o, 2);
      cyc();
      chk("R8 medium reported", stat_speed_o, 1);
      speed_cfg_i = 2'b10;
      cyc();
      chk("R8 slow reported", stat_speed_o, 2);
   endtask

   task automatic t_latch();
      speed_cfg_i = 2'b10;
      cyc();
      kick(1'b1);
      speed_cfg_i = 2'b00;
      chk("R9 pending after N", claim_n_o, 1);
      cyc();
      chk("R9 pending after N+1", claim_n_o, 1);
      cyc();
      chk("R9 claim at slow time", claim_n_o, 0);
      finish_txn();
   endtask

   task automatic t_restart();
      speed_cfg_i = 2'b10;
      cyc();
      kick(1'b1);
      speed_cfg_i = 2'b00;
      kick(1'b1);
      chk("R10 second start ignored", claim_n_o, 1);
      cyc();
      chk("R10 claim at original time", claim_n_o, 0);
      finish_txn();
   endtask

   task automatic t_abort();
      speed_cfg_i = 2'b10;
      cyc();
      kick(1'b1);
      txn_end_i = 1'b1;
      cyc();
      txn_end_i = 1'b0;
      for (int k = 0; k < 4; k++) begin
         chk("R11 aborted claim stays off", claim_n_o, 1);
         cyc();
      end
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      t_latency(2'b00, 1, "R2 fast latency");
      t_latency(2'b01, 2, "R3 medium latency");
      t_latency(2'b10, 3, "R4 slow latency");
      t_latency(2'b11, 3, "R4 reserved code as slow");
      t_nohit();
      t_gate_hold();
      t_status();
      t_latch();
      t_restart();
      t_abort();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 5000; i++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule